// File: doc/BRIEF.md
# Character-Oriented Receive Synchronizer with Sync Stripping and Block Check

This block sits behind a serial line receiver. A serial bit arrives in each cycle in which `bit_en` is high. While hunting, the block shifts every bit into a two-character window. It compares the window against a configured pair of sync characters after every shift, so it can lock at any bit position. Once it locks, it assembles characters least significant bit first and removes line filler. In normal mode the filler is the sync characters. In transparent mode the filler is escape-sync pairs and the first escape of a doubled escape. All other characters are delivered one at a time on `rx_data` / `rx_valid`.

A CRC-16 block check runs over the delivered characters. An end-of-block character is followed by two check bytes. The block then reports completion with a pass/fail result and falls back to hunting. An explicit hunt command or a malformed escape sequence also returns the block to hunting.

Top module: `bsc_rx_hunter`

## Requirements
- R1: While hunting, each `bit_en` cycle shifts `bit_in` into a 16-bit window, and bits in cycles without `bit_en` are ignored. Lock occurs when the last 16 bits received are `syn1` followed by `syn2`, each character sent least significant bit first. `syn1` alone does not lock.
- R2: `in_hunt` falls one clock after the `bit_en` cycle that completes the match. Character assembly starts with the next received bit.
- R3: Each delivered character appears on `rx_data` with `rx_valid` high for exactly one clock, one clock after the `bit_en` cycle of its eighth bit. The first bit received is bit 0.
- R4: In normal mode (`xparent`=0), a received character equal to `syn1` or `syn2` is dropped and kept out of the CRC.
- R5: In transparent mode (`xparent`=1), the escape character 0x10 is never delivered on its own. Escape followed by `syn1` or `syn2` is dropped entirely. Escape followed by escape delivers one 0x10, which enters the CRC once. A bare sync value is delivered as data.
- R6: End of block is ETX 0x03 or ETB 0x26 in normal mode, and escape followed by 0x03 or 0x26 in transparent mode. The terminator (without its escape) is delivered and enters the CRC. The next two characters are check bytes and are not delivered.
- R7: The check is CRC-16 x^16+x^15+x^2+1, processed least significant bit first (reflected constant 0xA001), starting from 0x0000. It covers the delivered characters of the block plus both check bytes, so a good block leaves 0. One clock after the last check-byte bit, `block_done` pulses for one clock, and `crc_error` pulses with it if the remainder is nonzero. The block is then hunting.
- R8: In transparent mode, an escape followed by any character other than escape, `syn1`, `syn2`, 0x03 or 0x26 pulses `frame_error` for one clock and returns to hunting. Nothing more is delivered until a new lock.
- R9: `hunt_cmd` sampled high forces hunting on the next clock, clears the window, and discards the bit and any partial character of that cycle.
- R10: After reset `in_hunt` is 1 and `rx_valid`, `block_done`, `crc_error` and `frame_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xparent | input | 1 | 1 selects transparent mode |
| syn1 | input | 8 | First sync character of the hunt pattern |
| syn2 | input | 8 | Second sync character of the hunt pattern |
| hunt_cmd | input | 1 | Force return to hunting |
| bit_en | input | 1 | Serial bit strobe |
| bit_in | input | 1 | Serial data bit |
| rx_data | output | 8 | Delivered character |
| rx_valid | output | 1 | `rx_data` holds a new character |
| block_done | output | 1 | Block check completed |
| crc_error | output | 1 | Block check failed (with `block_done`) |
| frame_error | output | 1 | Bad escape sequence seen |
| in_hunt | output | 1 | Receiver is hunting for sync |

## Verification
A wrong bit count or a window cleared at the wrong moment shows up as a late or early fall of `in_hunt`, or as characters delivered at a shifted bit phase. The behavioural model detects this on the first delivered character, one clock after its eighth bit. A wrong escape or strip state delivers an extra or missing byte on the very next character. A CRC slip stays hidden until the end of the block, where `crc_error` disagrees with the model. The model is compared on every clock, so a mismatch is reported in the exact cycle it first appears.

// File: rtl/bsc_rx_pkg.sv
package bsc_rx_pkg;
    typedef enum logic [2:0] {
        ST_HUNT = 3'd0,
        ST_DATA = 3'd1,
        ST_ESC  = 3'd2,
        ST_BCS1 = 3'd3,
        ST_BCS2 = 3'd4
    } rx_state_e;
endpackage

// File: rtl/bsc_crc_step.sv
module bsc_crc_step #(
    parameter int unsigned            CHAR_W = 8,
    parameter int unsigned            CRC_W  = 16,
    parameter logic [CRC_W-1:0]       POLY   = 16'hA001
) (
    input  logic [CRC_W-1:0]  crc_in,
    input  logic [CHAR_W-1:0] char_in,
    output logic [CRC_W-1:0]  crc_out
);
    always_comb begin
        crc_out = crc_in;
        for (int i = 0; i < CHAR_W; i++) begin
            if (crc_out[0] ^ char_in[i]) begin
                crc_out = (crc_out >> 1) ^ POLY;
            end else begin
                crc_out = crc_out >> 1;
            end
        end
    end
endmodule

// File: rtl/bsc_rx_shifter.sv
module bsc_rx_shifter #(
    parameter int unsigned CHAR_W = 8,
    localparam int unsigned SR_W  = 2 * CHAR_W,
    localparam int unsigned CNT_W = $clog2(CHAR_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              hunting,
    input  logic              clr,
    input  logic [SR_W-1:0]   pattern,
    output logic              match,
    output logic              byte_rdy,
    output logic [CHAR_W-1:0] byte_val
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAR_W - 1);

    typedef struct packed {
        logic [SR_W-1:0]  sr;
        logic [CNT_W-1:0] cnt;
        logic             hunt_prev;
    } sh_t;

    sh_t q, d;
    logic [SR_W-1:0] base;
    logic [SR_W-1:0] shifted;

    always_comb begin
        base    = (hunting && !q.hunt_prev) ? '0 : q.sr;
        shifted = {bit_in, base[SR_W-1:1]};
        d           = q;
        d.hunt_prev = hunting;
        if (clr) begin
            d.sr  = '0;
            d.cnt = '0;
        end else begin
            d.sr = bit_en ? shifted : base;
            if (hunting) begin
                d.cnt = '0;
            end else if (bit_en) begin
                d.cnt = (q.cnt == LAST) ? '0 : q.cnt + 1'b1;
            end
        end
        match    = hunting && bit_en && !clr && (shifted == pattern);
        byte_rdy = !hunting && bit_en && !clr && (q.cnt == LAST);
        byte_val = shifted[SR_W-1:CHAR_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sr        <= '0;
            q.cnt       <= '0;
            q.hunt_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/bsc_rx_hunter.sv
module bsc_rx_hunter
    import bsc_rx_pkg::*;
#(
    parameter int unsigned          CHAR_W   = 8,
    parameter int unsigned          CRC_W    = 16,
    parameter logic [CRC_W-1:0]     CRC_POLY = 16'hA001,
    parameter logic [CHAR_W-1:0]    ESC_CHAR = 8'h10,
    parameter logic [CHAR_W-1:0]    END_TXT  = 8'h03,
    parameter logic [CHAR_W-1:0]    END_BLK  = 8'h26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xparent,
    input  logic [CHAR_W-1:0] syn1,
    input  logic [CHAR_W-1:0] syn2,
    input  logic              hunt_cmd,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              block_done,
    output logic              crc_error,
    output logic              frame_error,
    output logic              in_hunt
);
    typedef struct packed {
        rx_state_e         st;
        logic [CRC_W-1:0]  crc;
        logic [CHAR_W-1:0] data;
        logic              valid;
        logic              done;
        logic              cerr;
        logic              ferr;
    } rx_regs_t;

    rx_regs_t q, d;

    logic              match, byte_rdy;
    logic [CHAR_W-1:0] byte_val;
    logic [CRC_W-1:0]  crc_nx;
    logic              is_sync, is_term, is_esc;

    bsc_rx_shifter #(.CHAR_W(CHAR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .hunting  (q.st == ST_HUNT),
        .clr      (hunt_cmd),
        .pattern  ({syn2, syn1}),
        .match    (match),
        .byte_rdy (byte_rdy),
        .byte_val (byte_val)
    );

    bsc_crc_step #(.CHAR_W(CHAR_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
        .crc_in  (q.crc),
        .char_in (byte_val),
        .crc_out (crc_nx)
    );

    always_comb begin
        is_sync = (byte_val == syn1) || (byte_val == syn2);
        is_term = (byte_val == END_TXT) || (byte_val == END_BLK);
        is_esc  = (byte_val == ESC_CHAR);

        d       = q;
        d.valid = 1'b0;
        d.done  = 1'b0;
        d.cerr  = 1'b0;
        d.ferr  = 1'b0;

        if (hunt_cmd) begin
            d.st = ST_HUNT;
        end else if (q.st == ST_HUNT) begin
            if (match) begin
                d.st  = ST_DATA;
                d.crc = '0;
            end
        end else if (byte_rdy) begin
            unique case (q.st)
                ST_DATA: begin
                    if (xparent && is_esc) begin
                        d.st = ST_ESC;
                    end else if (xparent || !is_sync) begin
                        d.valid = 1'b1;
                        d.data  = byte_val;
                        d.crc   = crc_nx;
                        if (!xparent && is_term) begin
                            d.st = ST_BCS1;
                        end
                    end
                end
                ST_ESC: begin
                    if (is_sync) begin
                        d.st = ST_DATA;
                    end else if (is_esc || is_term) begin
                        d.valid = 1'b1;
                        d.data  = byte_val;
                        d.crc   = crc_nx;
                        d.st    = is_term ? ST_BCS1 : ST_DATA;
                    end else begin
                        d.ferr = 1'b1;
                        d.st   = ST_HUNT;
                    end
                end
                ST_BCS1: begin
                    d.crc = crc_nx;
                    d.st  = ST_BCS2;
                end
                ST_BCS2: begin
                    d.done = 1'b1;
                    d.cerr = (crc_nx != '0);
                    d.st   = ST_HUNT;
                end
                default: d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_HUNT;
            q.crc   <= '0;
            q.data  <= '0;
            q.valid <= 1'b0;
            q.done  <= 1'b0;
            q.cerr  <= 1'b0;
            q.ferr  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rx_data     = q.data;
    assign rx_valid    = q.valid;
    assign block_done  = q.done;
    assign crc_error   = q.cerr;
    assign frame_error = q.ferr;
    assign in_hunt     = (q.st == ST_HUNT);

    AST_NO_VALID_IN_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !in_hunt);                                   // R3
    AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        block_done |-> (!rx_valid && in_hunt));                   // R7
    AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |-> block_done);                                // R7
    AST_HUNT_CMD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> (in_hunt && !rx_valid && !block_done));      // R9
    AST_FRAME_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_error |-> (in_hunt && $past(xparent)));             // R8
    AST_LOCK_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_hunt) |-> $past(bit_en));                        // R2
endmodule

// File: tb/sim_bsc_rx_hunter.sv
`timescale 1ns/100ps
module sim_bsc_rx_hunter;
    localparam logic [7:0] S1  = 8'h16;
    localparam logic [7:0] S2  = 8'h2C;
    localparam logic [7:0] ESC = 8'h10;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n, xparent, hunt_cmd, bit_en, bit_in;
    logic [7:0] rx_data;
    logic       rx_valid, block_done, crc_error, frame_error, in_hunt;

    bsc_rx_hunter u0 (
        .clk(clk), .rst_n(rst_n), .xparent(xparent), .syn1(S1), .syn2(S2),
        .hunt_cmd(hunt_cmd), .bit_en(bit_en), .bit_in(bit_in),
        .rx_data(rx_data), .rx_valid(rx_valid), .block_done(block_done),
        .crc_error(crc_error), .frame_error(frame_error), .in_hunt(in_hunt)
    );

    int checks = 0;
    int fails  = 0;
    bit done_flag = 0;

    // behavioural model: 0 hunt, 1 data, 2 after escape, 3/4 check bytes
    int          mst = 0;
    logic [15:0] hist = '0;
    int          nbit = 0;
    logic [7:0]  acc = '0;
    logic [15:0] mcrc = '0;
    logic        e_hunt = 1, e_valid = 0, e_done = 0, e_cerr = 0, e_ferr = 0;
    logic [7:0]  e_data = '0;

    int          n_done, n_cerr, n_ferr;
    logic [7:0]  got[$];
    logic [15:0] tcrc;

    function automatic logic [15:0] crc_add(logic [15:0] c, logic [7:0] v);
        c = c ^ {8'h00, v};
        repeat (8) c = c[0] ? ((c >> 1) ^ 16'hA001) : (c >> 1);
        return c;
    endfunction

    function automatic logic [15:0] arrival_order(logic [7:0] first, logic [7:0] second);
        logic [15:0] r;
        for (int i = 0; i < 8; i++) begin
            r[15 - i] = first[i];
            r[7 - i]  = second[i];
        end
        return r;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit is_syn(logic [7:0] c);
        return (c == S1) || (c == S2);
    endfunction

    function automatic bit is_end(logic [7:0] c);
        return (c == 8'h03) || (c == 8'h26);
    endfunction

    task automatic go_hunt();
        mst = 0; hist = '0; e_hunt = 1;
    endtask

    task automatic emit(logic [7:0] c);
        e_valid = 1; e_data = c; mcrc = crc_add(mcrc, c);
    endtask

    task automatic model_char(logic [7:0] c);
        case (mst)
            1: begin
                if (xparent && c == ESC) mst = 2;
                else if (xparent || !is_syn(c)) begin
                    emit(c);
                    if (!xparent && is_end(c)) mst = 3;
                end
            end
            2: begin
                if (is_syn(c)) mst = 1;
                else if (c == ESC) begin emit(c); mst = 1; end
                else if (is_end(c)) begin emit(c); mst = 3; end
                else begin e_ferr = 1; go_hunt(); end
            end
            3: begin mcrc = crc_add(mcrc, c); mst = 4; end
            default: begin
                mcrc = crc_add(mcrc, c);
                e_done = 1; e_cerr = (mcrc != 0);
                go_hunt();
            end
        endcase
    endtask

    task automatic model_update(bit en, bit b, bit hc);
        e_valid = 0; e_done = 0; e_cerr = 0; e_ferr = 0;
        if (hc) begin
            go_hunt();
        end else if (en) begin
            if (mst == 0) begin
                hist = {hist[14:0], b};
                if (hist == arrival_order(S1, S2)) begin
                    mst = 1; nbit = 0; acc = '0; mcrc = '0; e_hunt = 0;
                end
            end else begin
                acc[nbit] = b;
                nbit++;
                if (nbit == 8) begin
                    nbit = 0;
                    model_char(acc);
                    acc = '0;
                end
            end
        end
        if (hc) begin nbit = 0; acc = '0; end
    endtask

    task automatic compare_now();
        check(in_hunt == e_hunt, "R1 R2 R9", "in_hunt", in_hunt, e_hunt);
        check(rx_valid == e_valid, "R3 R4 R5", "rx_valid", rx_valid, e_valid);
        if (e_valid) check(rx_data == e_data, "R3", "rx_data", rx_data, e_data);
        check(block_done == e_done, "R6 R7", "block_done", block_done, e_done);
        check(crc_error == e_cerr, "R7", "crc_error", crc_error, e_cerr);
        check(frame_error == e_ferr, "R8", "frame_error", frame_error, e_ferr);
        if (rx_valid) got.push_back(rx_data);
        if (block_done) n_done++;
        if (crc_error) n_cerr++;
        if (frame_error) n_ferr++;
    endtask

    task automatic step(bit en, bit b, bit hc);
        @(negedge clk);
        compare_now();
        bit_en = en; bit_in = b; hunt_cmd = hc;
        model_update(en, b, hc);
    endtask

    task automatic send_char(logic [7:0] c);
        for (int i = 0; i < 8; i++) begin
            step(1'b1, c[i], 1'b0);
            step(1'b0, ~c[i], 1'b0);
        end
    endtask

    task automatic settle();
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic clear_counts();
        got.delete(); n_done = 0; n_cerr = 0; n_ferr = 0; tcrc = '0;
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            report();
        end
    end

    initial begin
        rst_n = 0; xparent = 0; hunt_cmd = 0; bit_en = 0; bit_in = 0;
        clear_counts();
        repeat (4) @(negedge clk);
        rst_n = 1;
        #1;
        check(in_hunt == 1 && rx_valid == 0 && block_done == 0 &&
              crc_error == 0 && frame_error == 0, "R10", "reset state",
              {in_hunt, rx_valid, block_done, crc_error, frame_error}, 5'b10000);

        // normal block, odd bit offset, syncs stripped, good check
        clear_counts();
        step(1, 1, 0); step(0, 0, 0); step(1, 0, 0); step(1, 1, 0);
        send_char(S1);
        check(in_hunt == 1, "R1", "in_hunt after syn1 only", in_hunt, 1);
        send_char(S2);
        check(in_hunt == 0, "R2", "in_hunt after pattern", in_hunt, 0);
        send_char(S1);
        send_char(8'h41); tcrc = crc_add(tcrc, 8'h41);
        send_char(8'h42); tcrc = crc_add(tcrc, 8'h42);
        send_char(S2);
        send_char(8'h43); tcrc = crc_add(tcrc, 8'h43);
        send_char(8'h03); tcrc = crc_add(tcrc, 8'h03);
        send_char(tcrc[7:0]); send_char(tcrc[15:8]);
        settle();
        check(got.size() == 4, "R4", "normal delivered count", got.size(), 4);
        if (got.size() == 4) begin
            check(got[0] == 8'h41 && got[2] == 8'h43, "R3", "normal data order", got[2], 8'h43);
            check(got[3] == 8'h03, "R6", "terminator delivered", got[3], 8'h03);
        end
        check(n_done == 1 && n_cerr == 0, "R7", "good block result", n_cerr, 0);
        check(in_hunt == 1, "R6", "hunting after block", in_hunt, 1);

        // normal block ending in ETB with corrupt check
        clear_counts();
        send_char(S1); send_char(S2);
        send_char(8'h44); tcrc = crc_add(tcrc, 8'h44);
        send_char(8'h26); tcrc = crc_add(tcrc, 8'h26);
        send_char(tcrc[7:0] ^ 8'h01); send_char(tcrc[15:8]);
        settle();
        check(got.size() == 2, "R6", "etb block count", got.size(), 2);
        check(n_done == 1 && n_cerr == 1, "R7", "bad check flagged", n_cerr, 1);

        // transparent block
        xparent = 1;
        clear_counts();
        send_char(S1); send_char(S2);
        send_char(ESC); send_char(ESC); tcrc = crc_add(tcrc, ESC);
        send_char(ESC); send_char(S1);
        send_char(S1); tcrc = crc_add(tcrc, S1);
        send_char(ESC); send_char(S2);
        send_char(8'h45); tcrc = crc_add(tcrc, 8'h45);
        send_char(ESC); send_char(8'h03); tcrc = crc_add(tcrc, 8'h03);
        send_char(tcrc[7:0]); send_char(tcrc[15:8]);
        settle();
        check(got.size() == 4, "R5", "transparent count", got.size(), 4);
        if (got.size() == 4) begin
            check(got[0] == ESC && got[1] == S1, "R5", "escape and bare sync", got[1], S1);
            check(got[3] == 8'h03, "R6", "transparent terminator", got[3], 8'h03);
        end
        check(n_done == 1 && n_cerr == 0, "R7", "transparent block good", n_cerr, 0);

        // framing error
        clear_counts();
        send_char(S1); send_char(S2);
        send_char(8'h46); send_char(ESC); send_char(8'h55);
        send_char(8'h47);
        settle();
        check(n_ferr == 1, "R8", "frame error count", n_ferr, 1);
        check(got.size() == 1, "R8", "nothing after frame error", got.size(), 1);
        check(in_hunt == 1, "R8", "hunting after frame error", in_hunt, 1);

        // hunt command mid-character
        xparent = 0;
        clear_counts();
        send_char(S1); send_char(S2); send_char(8'h48);
        step(1, 1, 0); step(1, 0, 0); step(1, 1, 0);
        step(1, 1, 1);
        step(0, 0, 0);
        check(in_hunt == 1, "R9", "hunt command honoured", in_hunt, 1);
        send_char(8'h49); send_char(8'h4A);
        settle();
        check(got.size() == 1, "R9", "no delivery after hunt command", got.size(), 1);

        done_flag = 1;
        report();
    end
endmodule